// File: doc/BRIEF.md
# Stereo DAC Digital Volume and Output Mixer

This block sits in front of a stereo DAC. It takes signed 24-bit left/right PCM sample pairs and returns one processed pair per accepted input. Each output channel picks its source from the two inputs: silence, left, right, or their average. The chosen source is then attenuated, its phase is optionally inverted, and the result is registered. A separate flag reports when a long run of silent input has muted the output.

Gain is programmed through a small write port. Gain writes are double buffered: a write fills a holding register, and a write that carries the update flag moves every channel's held value into the active set in the same cycle. A master address loads both holding registers at once. Gain changes can be held back until the channel's signal changes sign, so that the step is not audible. A sample-count timeout forces a held change through, and the timeout can be switched off. The right channel can be set to follow the left channel's active gain.

Register map (3-bit address, 8-bit data): 0 left gain, 1 right gain, 2 both gains, 3 phase (bit 0 left, bit 1 right), 4 control (bit 0 zero-cross enable, bit 1 right follows left, bit 2 automute enable, bit 3 timeout disable), 5 routing (bits [1:0] left output source, bits [3:2] right output source).

Top module: `dvm_stereo_vol`

## Requirements
- R1: After reset, both gains are 0xFF (unity), phase bits and control bits are 0, and routing is 4'b1001. An input pair therefore comes out unchanged, and out_mute is 0.
- R2: out_valid is high in the cycle after each cycle with in_valid high and low otherwise. out_left and out_right hold their values while out_valid is low.
- R3: A gain code of 0x00 gives zero output. A code N gives (255−N)×0.5 dB of attenuation. A code 255−12k gives exactly 2^−k, rounded toward minus infinity (an arithmetic right shift by k).
- R4: A gain write (address 0, 1 or 2) with the update flag at 0 changes no output.
- R5: A gain write with the update flag at 1 makes the held values of both channels active together, including values that earlier writes only held. Address 2 loads the same code into both channels.
- R6: When control bit 1 is 1, the right output uses the left channel's active gain instead of its own.
- R7: Phase bit 0 negates the left output and bit 1 negates the right output. Negating −2^23 gives 2^23−1.
- R8: Each routing field selects 00 = zero, 01 = left input, 10 = right input, 11 = (L+R)/2. The average is formed from a 25-bit sign-extended sum shifted right arithmetically by 1.
- R9: When control bit 0 is 1, a pending gain change on a channel waits for a sample whose routed source has a different sign bit from the previous sample. That sample still uses the old gain, and the next sample uses the new gain.
- R10: With zero-cross enabled, the 1024th sample after a change becomes pending still uses the old gain, and the 1025th uses the new gain. With control bit 3 at 1 there is no timeout.
- R11: When control bit 2 is 1, the 1024th consecutive input pair whose two samples are both zero comes out with out_mute at 1 and zero data. The first non-zero pair clears out_mute. With bit 2 at 0, out_mute stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | 8 | Register write data |
| cfg_upd | input | 1 | Commit-all-gains flag for gain writes |
| in_valid | input | 1 | Input pair valid |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |
| out_mute | output | 1 | Automute active for this output pair |

## Verification
A corrupted holding or active gain register shows up on the first output pair after the next committing write. When zero-cross is on, it shows up only after a sign change or after 1024 samples, so the tests drive crossings and full timeout runs on purpose. A wrong zero-run count changes out_mute only at the 1024-sample boundary, so that boundary is checked on both sides. Routing, phase and averaging errors appear on the very next output pair, and full-scale negative values are used to expose missing saturation.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  localparam int NCH          = 2;
  localparam int CODE_W       = 8;
  localparam int MANT_W       = 16;
  localparam int STEPS_PER_6DB = 12;
  localparam int ADR_GAIN_ALL = 2;
  localparam int ADR_PHASE    = 3;
  localparam int ADR_CTRL     = 4;
  localparam int ADR_ROUTE    = 5;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_AVG   = 2'b11
  } src_sel_e;

  // packed MSB first: bit0 = zc_en, bit3 = to_dis
  typedef struct packed {
    logic to_dis;
    logic am_en;
    logic r_follows_l;
    logic zc_en;
  } ctl_t;

  // fractional part of a 6 dB group, 0.5 dB per step, unity = 32768
  function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] f);
    case (f)
      4'd0:    mant_lut = 16'd32768;
      4'd1:    mant_lut = 16'd30935;
      4'd2:    mant_lut = 16'd29205;
      4'd3:    mant_lut = 16'd27571;
      4'd4:    mant_lut = 16'd26029;
      4'd5:    mant_lut = 16'd24573;
      4'd6:    mant_lut = 16'd23198;
      4'd7:    mant_lut = 16'd21900;
      4'd8:    mant_lut = 16'd20675;
      4'd9:    mant_lut = 16'd19519;
      4'd10:   mant_lut = 16'd18427;
      4'd11:   mant_lut = 16'd17396;
      default: mant_lut = 16'd32768;
    endcase
  endfunction
endpackage

// File: rtl/dvm_cfg_regs.sv
module dvm_cfg_regs
  import dvm_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [CODE_W-1:0]             data,
  input  logic                          upd,
  output logic [NCH-1:0][CODE_W-1:0]    hold_code,
  output logic [NCH-1:0][CODE_W-1:0]    tgt_code,
  output logic [NCH-1:0]                phase_inv,
  output ctl_t                          ctl,
  output logic [2*NCH-1:0]              route
);
  logic [NCH-1:0][CODE_W-1:0] hold_nxt;
  logic                       is_gain_adr;
  logic                       commit;

  assign is_gain_adr = (addr < AW'(NCH)) || (addr == AW'(ADR_GAIN_ALL));
  assign commit      = we && upd && is_gain_adr;

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    logic hit;
    assign hit         = we && ((addr == AW'(c)) || (addr == AW'(ADR_GAIN_ALL)));
    assign hold_nxt[c] = hit ? data : hold_code[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_code <= '1;
      tgt_code  <= '1;
    end else begin
      hold_code <= hold_nxt;
      if (commit) tgt_code <= hold_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_inv <= '0;
      ctl       <= '0;
      route     <= {SRC_RIGHT, SRC_LEFT};
    end else if (we) begin
      if (addr == AW'(ADR_PHASE)) phase_inv <= data[NCH-1:0];
      if (addr == AW'(ADR_CTRL))  ctl       <= ctl_t'(data[3:0]);
      if (addr == AW'(ADR_ROUTE)) route     <= data[2*NCH-1:0];
    end
  end
endmodule

// File: rtl/dvm_zc_gain.sv
module dvm_zc_gain
  import dvm_pkg::*;
#(
  parameter int TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CODE_W-1:0] tgt,
  input  logic              zc_en,
  input  logic              to_dis,
  input  logic              sign,
  output logic [CODE_W-1:0] live
);
  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;
  logic             prev_sign;
  logic             pending;
  logic             crossed;
  logic             expired;

  assign pending = (tgt != live);
  assign crossed = (sign != prev_sign);
  assign expired = (cnt == CNT_LAST) && !to_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= '1;
      cnt       <= '0;
      prev_sign <= 1'b0;
    end else begin
      if (accept) prev_sign <= sign;
      if (!zc_en) begin
        live <= tgt;
        cnt  <= '0;
      end else if (accept) begin
        if (pending && (crossed || expired)) begin
          live <= tgt;
          cnt  <= '0;
        end else if (pending) begin
          if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/dvm_chan_path.sv
module dvm_chan_path
  import dvm_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic signed [SW-1:0] src_l,
  input  logic signed [SW-1:0] src_r,
  input  logic [1:0]           sel,
  input  logic [CODE_W-1:0]    code,
  input  logic                 invert,
  output logic                 src_neg,
  output logic signed [SW-1:0] result
);
  localparam int PW = SW + MANT_W + 1;
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [PW-1:0] PMAX = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic signed [SW:0]     sum;
  logic signed [SW-1:0]   avg;
  logic signed [SW-1:0]   mixed;
  logic [CODE_W-1:0]      atten;
  logic [CODE_W-1:0]      group;
  logic [CODE_W-1:0]      frac;
  logic [CODE_W-1:0]      sh;
  logic [MANT_W-1:0]      mant;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   scaled;
  logic signed [SW-1:0]   gained;

  assign sum = {src_l[SW-1], src_l} + {src_r[SW-1], src_r};
  assign avg = SW'(sum >>> 1);

  always_comb begin
    case (src_sel_e'(sel))
      SRC_LEFT:  mixed = src_l;
      SRC_RIGHT: mixed = src_r;
      SRC_AVG:   mixed = avg;
      default:   mixed = '0;
    endcase
  end

  assign src_neg = mixed[SW-1];

  assign atten  = 8'd255 - code;
  assign group  = atten / 8'(STEPS_PER_6DB);
  assign frac   = atten % 8'(STEPS_PER_6DB);
  assign sh     = 8'(MANT_W - 1) + group;
  assign mant   = mant_lut(4'(frac));
  assign prod   = mixed * $signed({1'b0, mant});
  assign scaled = prod >>> sh;

  always_comb begin
    if (code == '0)           gained = '0;
    else if (scaled > PMAX)   gained = SMAX;
    else if (scaled < PMIN)   gained = SMIN;
    else                      gained = scaled[SW-1:0];

    if (!invert)              result = gained;
    else if (gained == SMIN)  result = SMAX;
    else                      result = -gained;
  end
endmodule

// File: rtl/dvm_automute.sv
module dvm_automute #(
  parameter int THRESH = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic is_zero,
  input  logic en,
  output logic mute_now
);
  localparam int CNT_W = $clog2(THRESH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] run;

  assign mute_now = en && is_zero && (run == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (accept) begin
      if (!is_zero)             run <= '0;
      else if (run != CNT_LAST) run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/dvm_stereo_vol.sv
module dvm_stereo_vol
  import dvm_pkg::*;
#(
  parameter int SW         = 24,
  parameter int AW         = 3,
  parameter int ZC_TIMEOUT = 1024,
  parameter int AM_THRESH  = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_data,
  input  logic          cfg_upd,
  input  logic          in_valid,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  output logic          out_valid,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right,
  output logic          out_mute
);
  logic [NCH-1:0][CODE_W-1:0] hold_code;
  logic [NCH-1:0][CODE_W-1:0] tgt_code;
  logic [NCH-1:0][CODE_W-1:0] live_code;
  logic [NCH-1:0][CODE_W-1:0] eff_code;
  logic [NCH-1:0]             phase_inv;
  logic [NCH-1:0]             src_neg;
  logic [NCH-1:0][SW-1:0]     chan_out;
  logic [2*NCH-1:0]           route;
  ctl_t                       ctl;
  logic                       mute_now;

  dvm_cfg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .upd(cfg_upd), .hold_code(hold_code), .tgt_code(tgt_code),
    .phase_inv(phase_inv), .ctl(ctl), .route(route)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dvm_zc_gain #(.TIMEOUT(ZC_TIMEOUT)) u_zc (
      .clk(clk), .rst(rst), .accept(in_valid), .tgt(tgt_code[c]),
      .zc_en(ctl.zc_en), .to_dis(ctl.to_dis), .sign(src_neg[c]),
      .live(live_code[c])
    );

    if (c == 1) begin : g_follow
      assign eff_code[c] = ctl.r_follows_l ? live_code[0] : live_code[c];
    end else begin : g_own
      assign eff_code[c] = live_code[c];
    end

    dvm_chan_path #(.SW(SW)) u_path (
      .src_l(in_left), .src_r(in_right), .sel(route[2*c+1:2*c]),
      .code(eff_code[c]), .invert(phase_inv[c]),
      .src_neg(src_neg[c]), .result(chan_out[c])
    );
  end

  dvm_automute #(.THRESH(AM_THRESH)) u_am (
    .clk(clk), .rst(rst), .accept(in_valid),
    .is_zero((in_left == '0) && (in_right == '0)),
    .en(ctl.am_en), .mute_now(mute_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      out_mute  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= mute_now ? '0 : chan_out[0];
        out_right <= mute_now ? '0 : chan_out[1];
        out_mute  <= mute_now;
      end
    end
  end
endmodule

// File: rtl/dvm_checker.sv
module dvm_checker
  import dvm_pkg::*;
#(
  parameter int SW = 24,
  parameter int AW = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_we,
  input logic [AW-1:0]              cfg_addr,
  input logic                       cfg_upd,
  input logic                       in_valid,
  input logic [SW-1:0]              in_left,
  input logic [SW-1:0]              in_right,
  input logic                       out_valid,
  input logic [SW-1:0]              out_left,
  input logic [SW-1:0]              out_right,
  input logic                       out_mute,
  input logic [NCH-1:0][CODE_W-1:0] hold_code,
  input logic [NCH-1:0][CODE_W-1:0] tgt_code
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right))); // R2
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst) (cfg_we && !cfg_upd) |=> $stable(tgt_code)); // R4
  AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (rst) (cfg_we && cfg_upd && (cfg_addr <= AW'(ADR_GAIN_ALL))) |=> (tgt_code == hold_code)); // R5
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst) out_mute |-> (out_left == '0 && out_right == '0)); // R11
  AST_MUTE_RELEASE: assert property (@(posedge clk) disable iff (rst) (in_valid && (in_left != '0 || in_right != '0)) |=> !out_mute); // R11
endmodule

bind dvm_stereo_vol dvm_checker #(.SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_upd(cfg_upd),
  .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
  .out_mute(out_mute), .hold_code(hold_code), .tgt_code(tgt_code)
);

// File: tb/sim_dvm_stereo_vol.sv
module sim_dvm_stereo_vol;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        cfg_upd = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        out_valid;
  logic [23:0] out_left;
  logic [23:0] out_right;
  logic        out_mute;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dvm_stereo_vol u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_upd(cfg_upd), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .out_mute(out_mute)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic u);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d; cfg_upd = u;
    @(negedge clk);
    cfg_we = 1'b0; cfg_upd = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input int l, input int r);
    @(negedge clk);
    in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int sl(); return int'($signed(out_left)); endfunction
  function automatic int sr(); return int'($signed(out_right)); endfunction

  task automatic send_chk(input string req, input int l, input int r, input int el, input int er);
    send(l, r);
    check_eq(req, "out_valid", int'(out_valid), 1);
    check_eq(req, "left", sl(), el);
    check_eq(req, "right", sr(), er);
  endtask

  task automatic t_reset();
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);
    check_eq("R1", "out_mute after reset", int'(out_mute), 0);
    send_chk("R1", 1000, -2000, 1000, -2000);
    @(negedge clk);
    check_eq("R2", "valid drops", int'(out_valid), 0);
    check_eq("R2", "left held", sl(), 1000);
  endtask

  task automatic t_gain();
    wr(3'd0, 8'hF3, 1'b1);
    send_chk("R3", 1000, -2000, 500, -2000);
    wr(3'd1, 8'hE7, 1'b0);
    send_chk("R4", 1000, -2000, 500, -2000);
    wr(3'd0, 8'hFF, 1'b1);
    send_chk("R5", 1000, -7, 1000, -2);
    wr(3'd1, 8'h00, 1'b1);
    send_chk("R3", 1000, -2000, 1000, 0);
    wr(3'd2, 8'hF3, 1'b1);
    send_chk("R5", 1000, -2000, 500, -1000);
    wr(3'd2, 8'hFF, 1'b1);
  endtask

  task automatic t_follow();
    wr(3'd1, 8'h00, 1'b1);
    wr(3'd4, 8'h02, 1'b0);
    send_chk("R6", 1000, -2000, 1000, -2000);
    wr(3'd4, 8'h00, 1'b0);
    send_chk("R6", 1000, -2000, 1000, 0);
    wr(3'd1, 8'hFF, 1'b1);
  endtask

  task automatic t_phase();
    wr(3'd3, 8'h01, 1'b0);
    send_chk("R7", 1000, -2000, -1000, -2000);
    wr(3'd3, 8'h03, 1'b0);
    send_chk("R7", -8388608, 5, 8388607, -5);
    wr(3'd3, 8'h00, 1'b0);
  endtask

  task automatic t_route();
    wr(3'd5, 8'h00, 1'b0);
    send_chk("R8", 100, -300, 0, 0);
    wr(3'd5, 8'h06, 1'b0);
    send_chk("R8", 100, -300, -300, 100);
    wr(3'd5, 8'h0F, 1'b0);
    send_chk("R8", 100, -300, -100, -100);
    send_chk("R8", 3, -4, -1, -1);
    send_chk("R8", -8388608, -8388608, -8388608, -8388608);
    wr(3'd5, 8'h09, 1'b0);
  endtask

  task automatic t_zero_cross();
    wr(3'd4, 8'h01, 1'b0);
    send_chk("R9", 1000, 1000, 1000, 1000);
    wr(3'd0, 8'h00, 1'b1);
    send_chk("R9", 1000, 1000, 1000, 1000);
    send_chk("R9", 2000, 1000, 2000, 1000);
    send_chk("R9", -500, 1000, -500, 1000);
    send_chk("R9", -600, 1000, 0, 1000);
    wr(3'd4, 8'h00, 1'b0);
    wr(3'd0, 8'hFF, 1'b1);
  endtask

  task automatic t_timeout();
    int bad;
    wr(3'd4, 8'h01, 1'b0);
    send(10, 10);
    wr(3'd0, 8'h00, 1'b1);
    bad = 0;
    for (int i = 0; i < 1023; i++) begin
      send(10, 10);
      if (sl() != 10) bad++;
    end
    check_eq("R10", "old gain before timeout", bad, 0);
    send_chk("R10", 10, 10, 10, 10);
    send_chk("R10", 10, 10, 0, 10);
    wr(3'd4, 8'h00, 1'b0);
    wr(3'd0, 8'hFF, 1'b1);
    wr(3'd4, 8'h09, 1'b0);
    send(10, 10);
    wr(3'd0, 8'h00, 1'b1);
    bad = 0;
    for (int i = 0; i < 1100; i++) begin
      send(10, 10);
      if (sl() != 10) bad++;
    end
    check_eq("R10", "no timeout when disabled", bad, 0);
    send_chk("R10", -10, 10, -10, 10);
    send_chk("R10", -10, 10, 0, 10);
    wr(3'd4, 8'h00, 1'b0);
    wr(3'd0, 8'hFF, 1'b1);
  endtask

  task automatic t_automute();
    int bad;
    wr(3'd4, 8'h04, 1'b0);
    bad = 0;
    for (int i = 0; i < 1023; i++) begin
      send(0, 0);
      if (out_mute) bad++;
    end
    check_eq("R11", "no mute before threshold", bad, 0);
    send(0, 0);
    check_eq("R11", "mute at 1024th zero", int'(out_mute), 1);
    send_chk("R11", 5, 0, 5, 0);
    check_eq("R11", "mute released", int'(out_mute), 0);
    wr(3'd4, 8'h00, 1'b0);
    bad = 0;
    for (int i = 0; i < 1100; i++) begin
      send(0, 0);
      if (out_mute) bad++;
    end
    check_eq("R11", "no mute when disabled", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gain();
    t_follow();
    t_phase();
    t_route();
    t_zero_cross();
    t_timeout();
    t_automute();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule